// File: doc/BRIEF.md
# Performance Monitor Counter Bank

This block holds a configurable number of 32-bit event counters and one 32-bit cycle counter, all programmed through a single-cycle register bus. Each write is taken at the rising clock edge while `bus_wr` is high. Reads are combinational: `bus_rdata` follows `bus_addr` in the same cycle. Each event counter watches one line of a 64-line strobe vector, picked by the event code in its type register. It can also be told to ignore activity at particular privilege levels. The cycle counter follows the same privilege filter. It can be slowed by a factor of 64, and it can be frozen while a debug-prohibit input is high.

Per-counter enable bits and interrupt-enable bits can only be changed through set and clear addresses. Overflow flags are cleared by writing ones to them. A single level interrupt stays high while any flagged counter also has its interrupt enabled. Event counters are reached indirectly: a select register names one counter, and two data addresses then act on that counter's type and value.

Register addresses (word index on `bus_addr`): 0 control, 1 enable-set, 2 enable-clear, 3 interrupt-enable-set, 4 interrupt-enable-clear, 5 overflow status, 6 select, 7 selected type, 8 selected count, 9 cycle count. In the enable, interrupt-enable and overflow registers, bit i (i < N_EVT) belongs to event counter i and bit 31 belongs to the cycle counter.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset every counter, enable, interrupt enable, overflow flag, type register and the select register read zero, `irq` is low, and the control register reads N_EVT in bits 15:11 with all other bits zero.
- R2: In the control register only bits 0 (global enable), 3 (divide cycle counting by 64), 4 (no function) and 5 (debug freeze) keep a written value. Bit 1 zeroes all event counters once and bit 2 zeroes the cycle counter and its divider once. Bits 1 and 2 always read zero, and bits 15:11 read N_EVT.
- R3: Event counter i adds one at a clock edge only when global enable, enable bit i, its event strobe and its privilege filter all hold at that edge.
- R4: In a type register, bit 31 blocks counting at privilege level 1 and bit 30 blocks it at level 0. Level 2 counts only when bit 27 is set, and level 3 never counts. The cycle counter applies the same rules using the type register reached with select value 31.
- R5: The event code is type bits 9:0. Strobe line code[5:0] drives the counter, and a code of 64 or above never counts.
- R6: On the set and clear addresses, a one bit sets or clears the matching mask bit and a zero bit leaves it alone. Both addresses read the current mask. Only bits N_EVT-1:0 and 31 can ever be set, in the enable, interrupt-enable and overflow registers.
- R7: A counter that wraps from 0xFFFFFFFF to zero sets its overflow flag. Writing ones to the overflow address clears those flags, and a wrap in the same cycle as a clear leaves the flag set.
- R8: `irq` is high exactly while some overflow flag is set together with its interrupt-enable bit.
- R9: A zeroing request from control bit 1 or bit 2 takes priority over an increment in the same cycle.
- R10: With control bit 3 clear, the cycle counter adds one for every qualifying cycle. With bit 3 set, it adds one on every 64th qualifying cycle, counted from the last cycle-counter zeroing.
- R11: While control bit 5 and `dbg_prohibit` are both high, the cycle counter holds its value.
- R12: The select register keeps 5 bits. A select value of N_EVT or above reads zero on the type and count addresses and ignores writes there, except that select 31 reaches the cycle counter's filter register, which keeps only bits 31, 30 and 27.
- R13: A write to a counter's value takes priority over an increment in the same cycle.
- R14: In an event type register only bits 31, 30, 27 and 9:0 keep a written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| evt_strobe | input | 64 | Event strobes, one line per event code |
| priv_lvl | input | 2 | Current privilege level, 0 to 3 |
| dbg_prohibit | input | 1 | Debug-prohibit level for the cycle-counter freeze |
| irq | output | 1 | Shared overflow interrupt, level |

## Verification
Most internal faults surface as a wrong count value. A broken filter, strobe index or priority choice is visible in the count on the first read after the stimulus that exercised it. A wrong divider phase appears as an early or late cycle-counter step, and the 63/64-cycle boundary check catches that to the exact edge. A corrupted overflow or interrupt mask shows on `irq` one cycle after the wrapping edge, and on the status read at the same time. A fault in a mask register shows on the very next read of either of its two addresses.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int DATA_W   = 32;
  localparam int STROBE_W = 64;
  localparam int CODE_W   = 10;
  localparam int ADDR_W   = 4;
  localparam int CYC_BIT  = 31;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_EN_SET = 4'd1;
  localparam logic [ADDR_W-1:0] A_EN_CLR = 4'd2;
  localparam logic [ADDR_W-1:0] A_IE_SET = 4'd3;
  localparam logic [ADDR_W-1:0] A_IE_CLR = 4'd4;
  localparam logic [ADDR_W-1:0] A_OVF    = 4'd5;
  localparam logic [ADDR_W-1:0] A_SEL    = 4'd6;
  localparam logic [ADDR_W-1:0] A_TYPE   = 4'd7;
  localparam logic [ADDR_W-1:0] A_CNT    = 4'd8;
  localparam logic [ADDR_W-1:0] A_CYC    = 4'd9;

  localparam logic [DATA_W-1:0] TYPE_WMASK     = 32'hC800_03FF;
  localparam logic [DATA_W-1:0] CYC_TYPE_WMASK = 32'hC800_0000;

  // Bits of the shared mask layout that belong to an existing counter.
  function automatic logic [DATA_W-1:0] owner_mask(int n_evt);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < CYC_BIT; i++) if (i < n_evt) m[i] = 1'b1;
    m[CYC_BIT] = 1'b1;
    return m;
  endfunction

  // Privilege filter: level 0 and 1 count unless excluded, level 2 only if included.
  function automatic logic level_ok(logic excl1, logic excl0, logic incl2, logic [1:0] lvl);
    case (lvl)
      2'd0:    return !excl0;
      2'd1:    return !excl1;
      2'd2:    return incl2;
      default: return 1'b0;
    endcase
  endfunction

  // Codes of 64 and above select no strobe line.
  function automatic logic strobe_hit(logic [CODE_W-1:0] code, logic [STROBE_W-1:0] s);
    return (code[CODE_W-1:6] == '0) && s[code[5:0]];
  endfunction
endpackage

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  // Zeroing beats loading, loading beats incrementing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  assign wrap = inc && !clr && !load && (&cnt);
endmodule

// File: rtl/pmc_prescale.sv
module pmc_prescale #(
  parameter int DIV_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic tick
);
  logic [DIV_W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clr)   q <= '0;
    else if (step)  q <= q + 1'b1;
  end

  assign tick = step && (&q);
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import pmc_pkg::*;
#(
  parameter int N_EVT      = 4,
  parameter int PRESCALE_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [STROBE_W-1:0] evt_strobe,
  input  logic [1:0]          priv_lvl,
  input  logic                dbg_prohibit,
  output logic                irq
);
  localparam int                SEL_W      = 5;
  localparam logic [SEL_W-1:0]  CYC_SEL    = SEL_W'(CYC_BIT);
  localparam logic [DATA_W-1:0] OWN_MASK   = owner_mask(N_EVT);
  localparam logic [5:0]        CTRL_WMASK = 6'b111001;
  localparam logic [4:0]        N_FIELD    = 5'(N_EVT);

  // Write decode
  logic wr_ctrl, wr_en_set, wr_en_clr, wr_ie_set, wr_ie_clr;
  logic wr_ovf, wr_sel, wr_type, wr_cnt, wr_cyc;
  always_comb begin
    wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
    wr_en_set = bus_wr && (bus_addr == A_EN_SET);
    wr_en_clr = bus_wr && (bus_addr == A_EN_CLR);
    wr_ie_set = bus_wr && (bus_addr == A_IE_SET);
    wr_ie_clr = bus_wr && (bus_addr == A_IE_CLR);
    wr_ovf    = bus_wr && (bus_addr == A_OVF);
    wr_sel    = bus_wr && (bus_addr == A_SEL);
    wr_type   = bus_wr && (bus_addr == A_TYPE);
    wr_cnt    = bus_wr && (bus_addr == A_CNT);
    wr_cyc    = bus_wr && (bus_addr == A_CYC);
  end

  // Control state and one-shot zeroing requests
  logic [5:0]        ctrl_q;
  logic [DATA_W-1:0] cnten_q, inten_q, ovf_q, cyc_type_q;
  logic [SEL_W-1:0]  sel_q;
  logic              evt_clr, cyc_clr;
  assign evt_clr = wr_ctrl && bus_wdata[1];
  assign cyc_clr = wr_ctrl && bus_wdata[2];

  // Event counters
  logic [DATA_W-1:0] evt_type [N_EVT];
  logic [DATA_W-1:0] evt_cnt  [N_EVT];
  logic [N_EVT-1:0]  evt_inc, evt_load, evt_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_EVT; i++) evt_type[i] <= '0;
    end else begin
      for (int i = 0; i < N_EVT; i++)
        if (wr_type && (sel_q == SEL_W'(i))) evt_type[i] <= bus_wdata & TYPE_WMASK;
    end
  end

  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    assign evt_inc[i] = ctrl_q[0] && cnten_q[i]
                     && strobe_hit(evt_type[i][CODE_W-1:0], evt_strobe)
                     && level_ok(evt_type[i][31], evt_type[i][30], evt_type[i][27], priv_lvl);
    assign evt_load[i] = wr_cnt && (sel_q == SEL_W'(i));

    pmc_counter #(.W(DATA_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (evt_clr),
      .load     (evt_load[i]),
      .load_val (bus_wdata),
      .inc      (evt_inc[i]),
      .cnt      (evt_cnt[i]),
      .wrap     (evt_wrap[i])
    );
  end

  // Cycle counter with divider, filter and debug freeze
  logic              cyc_qual, cyc_inc, pre_tick, cyc_wrap;
  logic [DATA_W-1:0] cyc_cnt;
  assign cyc_qual = ctrl_q[0] && cnten_q[CYC_BIT]
                 && level_ok(cyc_type_q[31], cyc_type_q[30], cyc_type_q[27], priv_lvl)
                 && !(ctrl_q[5] && dbg_prohibit);

  pmc_prescale #(.DIV_W(PRESCALE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cyc_clr),
    .step  (cyc_qual),
    .tick  (pre_tick)
  );

  assign cyc_inc = cyc_qual && (!ctrl_q[3] || pre_tick);

  pmc_counter #(.W(DATA_W)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cyc_clr),
    .load     (wr_cyc),
    .load_val (bus_wdata),
    .inc      (cyc_inc),
    .cnt      (cyc_cnt),
    .wrap     (cyc_wrap)
  );

  // Wrap events placed in the shared mask layout
  logic [DATA_W-1:0] wrap_vec;
  always_comb begin
    wrap_vec          = '0;
    wrap_vec[N_EVT-1:0] = evt_wrap;
    wrap_vec[CYC_BIT] = cyc_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      cnten_q    <= '0;
      inten_q    <= '0;
      ovf_q      <= '0;
      sel_q      <= '0;
      cyc_type_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[5:0] & CTRL_WMASK;
      if (wr_en_set)      cnten_q <= cnten_q | (bus_wdata & OWN_MASK);
      else if (wr_en_clr) cnten_q <= cnten_q & ~(bus_wdata & OWN_MASK);
      if (wr_ie_set)      inten_q <= inten_q | (bus_wdata & OWN_MASK);
      else if (wr_ie_clr) inten_q <= inten_q & ~(bus_wdata & OWN_MASK);
      ovf_q <= (ovf_q & ~(wr_ovf ? (bus_wdata & OWN_MASK) : '0)) | wrap_vec;
      if (wr_sel) sel_q <= bus_wdata[SEL_W-1:0];
      if (wr_type && (sel_q == CYC_SEL)) cyc_type_q <= bus_wdata & CYC_TYPE_WMASK;
    end
  end

  // Read path
  logic [DATA_W-1:0] rd_type, rd_cnt;
  always_comb begin
    rd_type = '0;
    rd_cnt  = '0;
    for (int i = 0; i < N_EVT; i++) begin
      if (sel_q == SEL_W'(i)) begin
        rd_type = evt_type[i];
        rd_cnt  = evt_cnt[i];
      end
    end
    if (sel_q == CYC_SEL) rd_type = cyc_type_q;
    case (bus_addr)
      A_CTRL:   bus_rdata = {16'h0, N_FIELD, 5'h0, ctrl_q};
      A_EN_SET,
      A_EN_CLR: bus_rdata = cnten_q;
      A_IE_SET,
      A_IE_CLR: bus_rdata = inten_q;
      A_OVF:    bus_rdata = ovf_q;
      A_SEL:    bus_rdata = {{(DATA_W-SEL_W){1'b0}}, sel_q};
      A_TYPE:   bus_rdata = rd_type;
      A_CNT:    bus_rdata = rd_cnt;
      A_CYC:    bus_rdata = cyc_cnt;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = |(ovf_q & inten_q);

  // Named taps for the checker
  logic [DATA_W-1:0] mon_cnt0;
  logic [3:0]        mon_code_hi0;
  assign mon_cnt0     = evt_cnt[0];
  assign mon_code_hi0 = evt_type[0][CODE_W-1:6];
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
  import pmc_pkg::*;
#(
  parameter int N_EVT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [6:0]        ctrl_fields,
  input logic              dp_bit,
  input logic              dbg_prohibit,
  input logic              irq,
  input logic [DATA_W-1:0] cnten_q,
  input logic [DATA_W-1:0] inten_q,
  input logic [DATA_W-1:0] ovf_q,
  input logic [DATA_W-1:0] cyc_cnt,
  input logic              cyc_wrap,
  input logic [DATA_W-1:0] mon_cnt0,
  input logic [3:0]        mon_code_hi0
);
  localparam logic [DATA_W-1:0] OWN = owner_mask(N_EVT);

  // R2
  ctrl_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> (ctrl_fields == {5'(N_EVT), 2'b00}));

  // R6
  own_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnten_q | inten_q | ovf_q) & ~OWN) == '0);

  // R7
  cyc_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wrap |=> ovf_q[CYC_BIT]);

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_wrap && inten_q[CYC_BIT] && !(bus_wr && bus_addr == A_IE_CLR)) |=> irq);

  // R11
  dbg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_bit && dbg_prohibit && !bus_wr) |=> $stable(cyc_cnt));

  // R5
  high_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mon_code_hi0 != 4'd0) && !bus_wr) |=> $stable(mon_cnt0));
endmodule

bind perf_ctr_bank pmc_checker #(.N_EVT(N_EVT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .ctrl_fields  ({bus_rdata[15:11], bus_rdata[2:1]}),
  .dp_bit       (ctrl_q[5]),
  .dbg_prohibit (dbg_prohibit),
  .irq          (irq),
  .cnten_q      (cnten_q),
  .inten_q      (inten_q),
  .ovf_q        (ovf_q),
  .cyc_cnt      (cyc_cnt),
  .cyc_wrap     (cyc_wrap),
  .mon_cnt0     (mon_cnt0),
  .mon_code_hi0 (mon_code_hi0)
);

// File: tb/tb_perf_ctr_bank.sv
`timescale 1ns/10ps
module tb_perf_ctr_bank;
  localparam int N_EVT = 4;
  localparam int NV    = 18;
  localparam logic [3:0] CTRL = 4'd0, ENS = 4'd1, ENC = 4'd2, IES = 4'd3, IEC = 4'd4;
  localparam logic [3:0] OVF = 4'd5, SEL = 4'd6, TYP = 4'd7, CNT = 4'd8, CYC = 4'd9;
  localparam logic [63:0] B5 = 64'h20, B6 = 64'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] evt_strobe = '0;
  logic [1:0]  priv_lvl = '0;
  logic        dbg_prohibit = 1'b0;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  perf_ctr_bank #(.N_EVT(N_EVT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_strobe(evt_strobe),
    .priv_lvl(priv_lvl), .dbg_prohibit(dbg_prohibit), .irq(irq)
  );

  // {req, write addr, write data, read addr, expected read}
  localparam logic [75:0] TBL [NV] = '{
    {4'd2,  CTRL, 32'h0000_003F, CTRL, 32'h0000_2039}, // R2
    {4'd2,  CTRL, 32'h0000_0000, CTRL, 32'h0000_2000}, // R2
    {4'd6,  ENS,  32'hFFFF_FFFF, ENC,  32'h8000_000F}, // R6
    {4'd6,  ENC,  32'h0000_0005, ENS,  32'h8000_000A}, // R6
    {4'd6,  ENC,  32'h0000_0000, ENS,  32'h8000_000A}, // R6
    {4'd6,  ENC,  32'hFFFF_FFFF, ENS,  32'h0000_0000}, // R6
    {4'd6,  IES,  32'h8000_0003, IEC,  32'h8000_0003}, // R6
    {4'd6,  IEC,  32'hFFFF_FFFF, IES,  32'h0000_0000}, // R6
    {4'd12, SEL,  32'hFFFF_FFE2, SEL,  32'h0000_0002}, // R12
    {4'd14, TYP,  32'hFFFF_FFFF, TYP,  32'hC800_03FF}, // R14
    {4'd14, TYP,  32'h0000_0000, TYP,  32'h0000_0000}, // R14
    {4'd12, SEL,  32'h0000_0007, TYP,  32'h0000_0000}, // R12
    {4'd12, TYP,  32'h0000_0011, TYP,  32'h0000_0000}, // R12
    {4'd12, CNT,  32'h0000_0005, CNT,  32'h0000_0000}, // R12
    {4'd12, SEL,  32'h0000_001F, SEL,  32'h0000_001F}, // R12
    {4'd12, TYP,  32'hFFFF_FFFF, TYP,  32'hC800_0000}, // R12
    {4'd12, TYP,  32'h0000_0000, TYP,  32'h0000_0000}, // R12
    {4'd7,  OVF,  32'hFFFF_FFFF, OVF,  32'h0000_0000}  // R7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #0.1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic hold(input logic [63:0] m, input int n);
    evt_strobe = m;
    repeat (n) @(negedge clk);
    evt_strobe = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state at every address
    for (int a = 0; a < 10; a++)
      rd_chk(4'(a), (a == 0) ? 32'h0000_2000 : 32'h0, $sformatf("R1 addr %0d", a));
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // Register table
    for (int i = 0; i < NV; i++) begin
      wr(TBL[i][71:68], TBL[i][67:36]);
      rd_chk(TBL[i][35:32], TBL[i][31:0], $sformatf("R%0d table %0d", TBL[i][75:72], i));
    end

    // R3: gating by strobe, global enable, own enable
    wr(SEL, 0); wr(TYP, 32'h5); wr(ENS, 32'h1); wr(CTRL, 32'h1);
    hold(B5, 10); rd_chk(CNT, 32'd10, "R3 strobe counts");
    hold(B6, 5);  rd_chk(CNT, 32'd10, "R3 other strobe");
    wr(CTRL, 32'h0); hold(B5, 5); rd_chk(CNT, 32'd10, "R3 global off");
    wr(CTRL, 32'h1); wr(ENC, 32'h1); hold(B5, 4); rd_chk(CNT, 32'd10, "R3 own enable off");
    wr(ENS, 32'h1);

    // R4: privilege filter on an event counter
    wr(TYP, 32'h8000_0005); priv_lvl = 2'd1; hold(B5, 4); rd_chk(CNT, 32'd10, "R4 level1 excluded");
    priv_lvl = 2'd0; hold(B5, 3); rd_chk(CNT, 32'd13, "R4 level0 allowed");
    wr(TYP, 32'h4000_0005); hold(B5, 2); rd_chk(CNT, 32'd13, "R4 level0 excluded");
    wr(TYP, 32'h5); priv_lvl = 2'd2; hold(B5, 2); rd_chk(CNT, 32'd13, "R4 level2 not included");
    wr(TYP, 32'h0800_0005); hold(B5, 2); rd_chk(CNT, 32'd15, "R4 level2 included");
    priv_lvl = 2'd3; hold(B5, 2); rd_chk(CNT, 32'd15, "R4 level3");
    priv_lvl = 2'd0;

    // R5: codes of 64 and above never count
    wr(TYP, 32'h45); hold('1, 6); rd_chk(CNT, 32'd15, "R5 code 69");
    wr(TYP, 32'h5);  hold('1, 6); rd_chk(CNT, 32'd21, "R5 code 5");

    // R7 and R8: wrap, flag, interrupt, write-one-to-clear
    wr(CNT, 32'hFFFF_FFFE); hold(B5, 2);
    rd_chk(CNT, 32'h0, "R7 wrapped value");
    rd_chk(OVF, 32'h1, "R7 flag set");
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    wr(IES, 32'h1); #0.1; chk("R8 irq enabled", {31'b0, irq}, 32'h1);
    wr(OVF, 32'h0); rd_chk(OVF, 32'h1, "R7 zero write keeps flag");
    wr(OVF, 32'h1); rd_chk(OVF, 32'h0, "R7 one clears flag");
    chk("R8 irq drops", {31'b0, irq}, 32'h0);

    // R13: write beats increment
    evt_strobe = B5; wr(CNT, 32'd100); evt_strobe = '0;
    rd_chk(CNT, 32'd100, "R13 write priority");

    // R9: zeroing beats increment
    evt_strobe = B5; wr(CTRL, 32'h3); evt_strobe = '0;
    rd_chk(CNT, 32'd0, "R9 event zeroing");
    rd_chk(CTRL, 32'h0000_2001, "R2 one-shot bits read zero");

    // R10: cycle counter, plain and divided
    wr(SEL, 32'd31); wr(TYP, 32'h0); wr(ENS, 32'h8000_0000);
    wr(CTRL, 32'h5); idle(20); rd_chk(CYC, 32'd20, "R10 every cycle");
    wr(CTRL, 32'hD); idle(63); rd_chk(CYC, 32'd0, "R10 divided before 64");
    idle(1); rd_chk(CYC, 32'd1, "R10 divided at 64");

    // R11: debug freeze
    dbg_prohibit = 1'b1; wr(CTRL, 32'h25); idle(10);
    rd_chk(CYC, 32'd0, "R11 frozen");
    dbg_prohibit = 1'b0; idle(10); rd_chk(CYC, 32'd10, "R11 released");

    // R7 and R8 on the cycle counter
    wr(IES, 32'h8000_0000); wr(CYC, 32'hFFFF_FFFF); idle(1);
    rd_chk(CYC, 32'h0, "R7 cycle wrap value");
    rd_chk(OVF, 32'h8000_0000, "R7 cycle flag");
    chk("R8 cycle irq", {31'b0, irq}, 32'h1);

    // R4: cycle counter filter
    wr(TYP, 32'h8000_0000); priv_lvl = 2'd1; wr(CYC, 32'h0); idle(5);
    rd_chk(CYC, 32'd0, "R4 cycle level1 excluded");
    priv_lvl = 2'd0; idle(3); rd_chk(CYC, 32'd3, "R4 cycle level0 counts");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule